// File: doc/BRIEF.md
# USART Bit-Clock Generator

This block produces all bit-rate timing for a serial transceiver: the strobes that advance the transmit shifter and the strobes that let the receiver sample. It does not move data. It supports four clocking modes. Plain asynchronous and double-speed asynchronous use a divided system clock with a fixed oversampling ratio. Synchronous master drives a transfer clock out on a pin. Synchronous slave takes a transfer clock in from that pin, synchronizes it to the system clock and detects its edges.

A down-counting divisor makes a base tick that the transmitter and receiver share. In the asynchronous modes the receiver gets every tick as its oversampling strobe, and a prescaler turns ticks into transmit bit strobes. In the synchronous modes each strobe is tied to one edge of the transfer clock, and a polarity input chooses which edge launches and which edge samples. All control inputs are plain levels. There is no data stream, so there is no valid/ready handshake.

Top module: `usart_clkgen`

## Requirements
- R1: While `rst_ni` is low, `tx_en_o`, `rx_en_o`, `xclk_o` and `xclk_oe_o` are all 0.
- R2: In both asynchronous modes (`sync_mode_i`=0), `rx_en_o` is a one-cycle pulse every D+1 system clocks, where D is `divisor_i`. With D=0 it is high on every cycle.
- R3: In normal asynchronous mode (`dbl_speed_i`=0), `tx_en_o` is a one-cycle pulse every 16·(D+1) system clocks.
- R4: In double-speed asynchronous mode (`dbl_speed_i`=1), `tx_en_o` pulses every 8·(D+1) system clocks. `rx_en_o` keeps the R2 rate.
- R5: In the asynchronous modes, `xclk_oe_o` and `xclk_o` stay 0, and `polarity_i` has no effect on either strobe.
- R6: In synchronous master mode (`sync_mode_i`=1, `xclk_master_i`=1), `xclk_oe_o` is 1 and `xclk_o` changes level every D+1 system clocks. A full transfer-clock period is therefore 2·(D+1) clocks.
- R7: In synchronous master mode, `tx_en_o` and `rx_en_o` each pulse once per transfer-clock period, D+1 clocks apart, and are never high together in a synchronous mode. With `polarity_i`=0, `tx_en_o` is high in the cycle in which `xclk_o` first reads 1 (launch on rising edge). With `polarity_i`=1, that cycle has `xclk_o`=0 (launch on falling edge).
- R8: In the synchronous modes, `dbl_speed_i` has no effect on any output.
- R9: In synchronous slave mode (`sync_mode_i`=1, `xclk_master_i`=0), `xclk_oe_o` and `xclk_o` stay 0. A launch edge on `xclk_i` (rising for `polarity_i`=0, falling for 1) gives one `tx_en_o` pulse, and the other edge gives one `rx_en_o` pulse. Either pulse is high in the third system-clock cycle after the first rising clock edge that sees the new pin level. `xclk_i` must run slower than a quarter of the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| divisor_i | input | DIV_W (12) | Baud divisor D; base tick period is D+1 clocks |
| sync_mode_i | input | 1 | 0 asynchronous, 1 synchronous |
| xclk_master_i | input | 1 | In synchronous mode: 1 drives the transfer clock, 0 receives it |
| dbl_speed_i | input | 1 | Halves the asynchronous oversampling ratio |
| polarity_i | input | 1 | Synchronous launch/sample edge select |
| xclk_i | input | 1 | Transfer-clock pin input (slave mode) |
| xclk_o | output | 1 | Transfer-clock pin output (master mode) |
| xclk_oe_o | output | 1 | Output enable for the transfer-clock pin |
| tx_en_o | output | 1 | Transmit bit strobe, one cycle |
| rx_en_o | output | 1 | Receive sample/oversample strobe, one cycle |

## Verification
The bench builds the block with its default parameters: a 12-bit divisor, 16× oversampling and a two-stage synchronizer. Because the divisor is a run-time input, small values from 0 to 4 still put several full transmit periods inside a few hundred cycles, including the degenerate every-cycle tick. The two-stage synchronizer makes the slave latency a fixed three cycles, so the bench can check it cycle by cycle for both polarities.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

  typedef enum logic [1:0] {
    CM_ASYNC      = 2'd0,
    CM_ASYNC_FAST = 2'd1,
    CM_SYNC_MST   = 2'd2,
    CM_SYNC_SLV   = 2'd3
  } clk_mode_e;

  function automatic clk_mode_e decode_mode(input logic sync_mode,
                                            input logic master,
                                            input logic dbl_speed);
    clk_mode_e m;
    if (!sync_mode) m = dbl_speed ? CM_ASYNC_FAST : CM_ASYNC;
    else            m = master ? CM_SYNC_MST : CM_SYNC_SLV;
    return m;
  endfunction

endpackage

// File: rtl/ucg_baud_cnt.sv
module ucg_baud_cnt #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (at_zero) begin
      cnt_q  <= divisor_i;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/ucg_async_psc.sv
module ucg_async_psc #(
  parameter int OVS_LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fast_i,
  output logic term_o
);

  localparam int FAST_LOG2 = OVS_LOG2 - 1;

  logic [OVS_LOG2-1:0] psc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (tick_i) psc_q <= psc_q + 1'b1;
  end

  // Terminal count: full ratio normally, half ratio in fast mode.
  assign term_o = fast_i ? (&psc_q[FAST_LOG2-1:0]) : (&psc_q);

endmodule

// File: rtl/ucg_xclk_sync.sv
module ucg_xclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xclk_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= xclk_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clkgen_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int OVS_LOG2    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             sync_mode_i,
  input  logic             xclk_master_i,
  input  logic             dbl_speed_i,
  input  logic             polarity_i,
  input  logic             xclk_i,
  output logic             xclk_o,
  output logic             xclk_oe_o,
  output logic             tx_en_o,
  output logic             rx_en_o
);

  clk_mode_e mode;
  logic      tick;
  logic      psc_term;
  logic      ext_rise;
  logic      ext_fall;

  logic tx_q, rx_q, xclk_q, oe_q;

  assign mode = decode_mode(sync_mode_i, xclk_master_i, dbl_speed_i);

  ucg_baud_cnt #(.DIV_W(DIV_W)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .divisor_i (divisor_i),
    .tick_o    (tick)
  );

  ucg_async_psc #(.OVS_LOG2(OVS_LOG2)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .fast_i (mode == CM_ASYNC_FAST),
    .term_o (psc_term)
  );

  ucg_xclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .xclk_i (xclk_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      xclk_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      unique case (mode)
        CM_ASYNC, CM_ASYNC_FAST: begin
          tx_q   <= tick & psc_term;
          rx_q   <= tick;
          xclk_q <= 1'b0;
          oe_q   <= 1'b0;
        end
        CM_SYNC_MST: begin
          // Launch on the edge that leaves the polarity level, sample on the other.
          tx_q <= tick & (xclk_q == polarity_i);
          rx_q <= tick & (xclk_q != polarity_i);
          if (tick) xclk_q <= ~xclk_q;
          oe_q <= 1'b1;
        end
        default: begin
          tx_q   <= polarity_i ? ext_fall : ext_rise;
          rx_q   <= polarity_i ? ext_rise : ext_fall;
          xclk_q <= 1'b0;
          oe_q   <= 1'b0;
        end
      endcase
    end
  end

  assign tx_en_o   = tx_q;
  assign rx_en_o   = rx_q;
  assign xclk_o    = xclk_q;
  assign xclk_oe_o = oe_q;

endmodule

// File: rtl/ucg_checker.sv
module ucg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_mode_i,
  input logic polarity_i,
  input logic xclk_o,
  input logic xclk_oe_o,
  input logic tx_en_o,
  input logic rx_en_o
);

  // R5: asynchronous mode releases the pin on the next cycle
  p_oe_async_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_mode_i |=> !xclk_oe_o);

  // R5, R9: the pin output is quiet whenever it is not enabled
  p_pin_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xclk_oe_o |-> !xclk_o);

  // R7: launch and sample strobes never coincide in synchronous modes
  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_mode_i) |-> !(tx_en_o && rx_en_o));

  // R7: in master mode the launch strobe meets the post-launch level
  p_launch_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && xclk_oe_o) |-> (xclk_o != $past(polarity_i)));

  // R3: an asynchronous transmit strobe lasts one cycle
  p_tx_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && !sync_mode_i && $past(!sync_mode_i)) |=> !tx_en_o);

endmodule

bind usart_clkgen ucg_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_mode_i (sync_mode_i),
  .polarity_i  (polarity_i),
  .xclk_o      (xclk_o),
  .xclk_oe_o   (xclk_oe_o),
  .tx_en_o     (tx_en_o),
  .rx_en_o     (rx_en_o)
);

// File: tb/tb_usart_clkgen.sv
module tb_usart_clkgen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] divisor = '0;
  logic        sync_mode = 1'b0, master = 1'b0, dbl = 1'b0, pol = 1'b0, xclk_in = 1'b0;
  logic        xclk_out, xclk_oe, tx_en, rx_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usart_clkgen dut (
    .clk_i(clk), .rst_ni(rst_n), .divisor_i(divisor), .sync_mode_i(sync_mode),
    .xclk_master_i(master), .dbl_speed_i(dbl), .polarity_i(pol), .xclk_i(xclk_in),
    .xclk_o(xclk_out), .xclk_oe_o(xclk_oe), .tx_en_o(tx_en), .rx_en_o(rx_en)
  );

  typedef struct packed {
    bit        sync;
    bit        mst;
    bit        dbl;
    bit        pol;
    bit [11:0] div;
    int        tx_per;
    int        rx_per;
    int        half;   // expected xclk_o half period, 0 = never toggles
    bit        oe;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 12'd3, 64, 4, 0, 1'b0},  // R2 R3
    '{1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 16, 1, 0, 1'b0},  // R2 R3 divisor 0
    '{1'b0, 1'b0, 1'b1, 1'b0, 12'd4, 40, 5, 0, 1'b0},  // R4
    '{1'b0, 1'b1, 1'b1, 1'b1, 12'd2, 24, 3, 0, 1'b0},  // R5 polarity ignored
    '{1'b1, 1'b1, 1'b0, 1'b0, 12'd3,  8, 8, 4, 1'b1},  // R6 R7
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'd3,  8, 8, 4, 1'b1},  // R7 R8
    '{1'b1, 1'b1, 1'b0, 1'b0, 12'd0,  2, 2, 1, 1'b1}   // R6 divisor 0
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int tx_cnt = 0, rx_cnt = 0, tg_cnt = 0;
    int tx_prev = 0, rx_prev = 0, tg_prev = 0;
    int tx_int = -1, rx_int = -1, tg_int = 0;
    int oe_err = 0, lvl_err = 0, gap = -1;
    logic prev_x = 1'b0;
    sync_mode = v.sync; master = v.mst; dbl = v.dbl; pol = v.pol; divisor = v.div;
    do_reset();
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (xclk_oe !== v.oe) oe_err++;
      if (tx_en) begin
        tx_cnt++;
        if (tx_cnt == 3) tx_int = c - tx_prev;
        tx_prev = c;
        if (v.sync && (xclk_out !== ~v.pol)) lvl_err++;
      end
      if (rx_en) begin
        rx_cnt++;
        if (rx_cnt == 3) rx_int = c - rx_prev;
        if (v.sync && rx_cnt == 3) gap = c - tx_prev;
        rx_prev = c;
      end
      if (c > 0 && xclk_out !== prev_x) begin
        tg_cnt++;
        if (tg_cnt == 3) tg_int = c - tg_prev;
        tg_prev = c;
      end
      prev_x = xclk_out;
    end
    $display("vector %0d", idx);
    chk(v.dbl && !v.sync ? "R4 tx period" : "R3/R7 tx period", tx_int, v.tx_per);
    chk("R2/R7 rx period", rx_int, v.rx_per);
    chk("R5/R6 xclk_oe level", oe_err, 0);
    chk("R5/R6 xclk_o half period", tg_int, v.half);
    if (v.sync) begin
      chk("R7 launch level vs polarity", lvl_err, 0);
      chk("R7 rx follows tx by half period", gap, v.half);
    end
  endtask

  // R9: drive a pin edge and watch one strobe appear in the third cycle
  task automatic slave_edge(input logic level, input bit want_tx, input string req);
    @(negedge clk) xclk_in = level;
    @(negedge clk);
    @(negedge clk);
    chk({req, " early"}, want_tx ? int'(tx_en) : int'(rx_en), 0);
    @(negedge clk);
    chk({req, " pulse"}, want_tx ? int'(tx_en) : int'(rx_en), 1);
    chk({req, " other strobe"}, want_tx ? int'(rx_en) : int'(tx_en), 0);
    @(negedge clk);
    chk({req, " single"}, want_tx ? int'(tx_en) : int'(rx_en), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    sync_mode = 1'b1; master = 1'b1; divisor = 12'd0;
    repeat (3) @(negedge clk);
    chk("R1 tx_en in reset", int'(tx_en), 0);
    chk("R1 rx_en in reset", int'(rx_en), 0);
    chk("R1 xclk_o in reset", int'(xclk_out), 0);
    chk("R1 xclk_oe in reset", int'(xclk_oe), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R9: slave mode, polarity 0 then 1
    sync_mode = 1'b1; master = 1'b0; dbl = 1'b0; pol = 1'b0; divisor = 12'd1;
    xclk_in = 1'b0;
    do_reset();
    repeat (5) @(negedge clk);
    chk("R9 xclk_oe slave", int'(xclk_oe), 0);
    chk("R9 xclk_o slave", int'(xclk_out), 0);
    slave_edge(1'b1, 1'b1, "R9 pol0 rising->tx");
    slave_edge(1'b0, 1'b0, "R9 pol0 falling->rx");
    pol = 1'b1;
    repeat (2) @(negedge clk);
    slave_edge(1'b1, 1'b0, "R9 pol1 rising->rx");
    slave_edge(1'b0, 1'b1, "R9 pol1 falling->tx");
    // R8: double speed has no effect in slave mode
    dbl = 1'b1;
    slave_edge(1'b1, 1'b0, "R8 slave dbl rising->rx");
    chk("R9 xclk_oe after edges", int'(xclk_oe), 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule